// File: doc/BRIEF.md
# Host Mailbox Message Channel

This block carries short messages in both directions between a host processor and an embedded engine. The host reaches it through a small register window selected by a three-bit index. One data register serves both directions: a host write to it pushes a word into the inbound queue, and a host read from it pops a word from the outbound queue. The engine has its own pop port on the inbound queue and its own push port on the outbound queue. Messages are two words long, so each queue holds two words.

A status register reports the fill state of both queues as not-empty and not-full bits at fixed positions, along with four interrupt flags. A control register gates pushes into each queue and enables each interrupt. The block also holds a mailbox word, which the engine can set bit by bit and the host can clear with a fixed key value. It also holds a two-entry watch queue, which the engine fills and the host drains by reading until the valid bit is clear. One interrupt line is the OR of the four flags.

Register index: 0 data, 1 status, 2 control, 3 mailbox, 4 watch. Reads of any other index return zero.

Top module: `msgq_mailbox`

## Requirements
- R1: After reset, status reads 0x00060000 (both queues empty), control and mailbox read 0, and `irq` is low.
- R2: Status bit 16 is outbound not-empty, bit 17 inbound not-full, bit 18 outbound not-full, and bit 19 inbound not-empty. `eng_in_avail` mirrors bit 19 and `eng_out_space` mirrors bit 18.
- R3: A host write to index 0 pushes the word into the inbound queue only while control bit 25 is set; otherwise it is dropped. The engine pops words in the order they were written.
- R4: An engine push enters the outbound queue only while control bit 24 is set. Host reads of index 0 pop the words in the order they were pushed.
- R5: Each queue holds two words. After one word the queue still reports not-full, and a push into a full queue is dropped.
- R6: A pop from an empty queue (host read of index 0, or `eng_pop`) returns zero and changes no state.
- R7: Status flags: bit 20 is control bit 20 AND mailbox nonzero; bit 21 is control bit 17 AND inbound empty; bit 22 is control bit 16 AND outbound not-empty; bit 23 is control bit 23 AND watch queue not-empty. `irq` is the OR of the four flags.
- R8: Each cycle, `eng_mbox_set` bits are ORed into the mailbox. A host write of 0x0000F0F0 to index 3 clears it, and a host write of any other value to index 3 is ignored.
- R9: Each host read of index 4 pops the watch queue and returns bit 31 set with the 31-bit entry below it. It returns zero when the queue is empty. The queue is two deep, and engine pushes into a full watch queue are dropped.
- R10: Control keeps only bits 16, 17, 20, 23, 24 and 25, and reads back zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 3 | Register index |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd_en | input | 1 | Host read strobe (pops at index 0 or 4) |
| host_rdata | output | 32 | Read data for the selected index, valid in the strobe cycle |
| eng_pop | input | 1 | Engine pop from inbound queue |
| eng_pop_data | output | 32 | Inbound head word, zero when empty |
| eng_in_avail | output | 1 | Inbound queue not empty |
| eng_push | input | 1 | Engine push into outbound queue |
| eng_push_data | input | 32 | Outbound word |
| eng_out_space | output | 1 | Outbound queue not full |
| eng_watch_push | input | 1 | Engine push into watch queue |
| eng_watch_data | input | 31 | Watch entry |
| eng_mbox_set | input | 32 | Mailbox bits to set |
| irq | output | 1 | OR of the status interrupt flags |

## Verification
The hardest states to reach are the interrupt flags. Each one combines an enable bit with the state of a different store, and the inbound flag is active when its queue is empty. The bench sweeps all sixteen enable patterns against all sixteen combinations of the four store conditions. It builds each condition through the normal push and set ports, then sets the enables and checks the whole status word and `irq`. Full and empty boundaries are covered by sweeping zero to three pushes against zero to three pops on each queue.

// File: rtl/msgq_pkg.sv
// Shared register indices and bit positions for the host mailbox channel.
// Assumes a 32-bit host register window.
package msgq_pkg;
    localparam int unsigned REG_W = 32;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_MBOX  = 3'd3,
        SEL_WATCH = 3'd4
    } msgq_sel_e;

    localparam int unsigned ST_OUT_NE  = 16;
    localparam int unsigned ST_IN_NF   = 17;
    localparam int unsigned ST_OUT_NF  = 18;
    localparam int unsigned ST_IN_NE   = 19;
    localparam int unsigned ST_MB_INT  = 20;
    localparam int unsigned ST_IN_INT  = 21;
    localparam int unsigned ST_OUT_INT = 22;
    localparam int unsigned ST_WF_INT  = 23;

    localparam int unsigned CT_OUT_IEN = 16;
    localparam int unsigned CT_IN_IEN  = 17;
    localparam int unsigned CT_MB_IEN  = 20;
    localparam int unsigned CT_WF_IEN  = 23;
    localparam int unsigned CT_OUT_WEN = 24;
    localparam int unsigned CT_IN_WEN  = 25;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (32'd1 << CT_OUT_IEN) | (32'd1 << CT_IN_IEN) | (32'd1 << CT_MB_IEN) |
        (32'd1 << CT_WF_IEN)  | (32'd1 << CT_OUT_WEN) | (32'd1 << CT_IN_WEN);

    localparam logic [REG_W-1:0] MBOX_CLR_KEY = 32'h0000_F0F0;
endpackage

// File: rtl/msgq_fifo.sv
// Small synchronous queue. A push into a full queue and a pop from an empty
// queue are dropped. The head is shown combinationally and reads zero when empty.
// Assumes push and pop are single-cycle strobes.
module msgq_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R5
    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full && $stable(wr_ptr)); // R5
    AST_EMPTY_POP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty && $stable(rd_ptr)); // R6
endmodule

// File: rtl/msgq_irq.sv
// Interrupt flag generation. Each flag is its enable ANDed with its store
// condition, and the interrupt line is the OR of all flags.
// Assumes the control word is already masked to defined bits.
module msgq_irq
    import msgq_pkg::*;
(
    input  logic [REG_W-1:0] ctrl,
    input  logic             out_ne,
    input  logic             in_empty,
    input  logic             mbox_nz,
    input  logic             watch_ne,
    output logic [3:0]       flags,
    output logic             irq
);
    // Flag order: mailbox, inbound, outbound, watch (status bits 20..23).
    always_comb begin
        flags[0] = ctrl[CT_MB_IEN]  && mbox_nz;
        flags[1] = ctrl[CT_IN_IEN]  && in_empty;
        flags[2] = ctrl[CT_OUT_IEN] && out_ne;
        flags[3] = ctrl[CT_WF_IEN]  && watch_ne;
        irq      = |flags;
    end
endmodule

// File: rtl/msgq_mailbox.sv
// Host mailbox message channel top. It provides the host register window,
// the inbound and outbound message queues, the watch queue, the mailbox word
// and the interrupts. Assumes host strobes last one cycle, and host_rdata is
// sampled in the strobe cycle (the pop takes effect at the following edge).
module msgq_mailbox
    import msgq_pkg::*;
#(
    parameter int unsigned MSG_DEPTH   = 2,
    parameter int unsigned WATCH_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  host_sel,
    input  logic        host_wr_en,
    input  logic [31:0] host_wdata,
    input  logic        host_rd_en,
    output logic [31:0] host_rdata,
    input  logic        eng_pop,
    output logic [31:0] eng_pop_data,
    output logic        eng_in_avail,
    input  logic        eng_push,
    input  logic [31:0] eng_push_data,
    output logic        eng_out_space,
    input  logic        eng_watch_push,
    input  logic [30:0] eng_watch_data,
    input  logic [31:0] eng_mbox_set,
    output logic        irq
);
    localparam int unsigned WATCH_W = REG_W - 1;

    msgq_sel_e        sel;
    logic [REG_W-1:0] ctrl_q, mbox_q, status;
    logic             in_push, out_push, out_pop, watch_pop, mbox_clr;
    logic             in_empty, in_full, out_empty, out_full;
    logic             w_empty, w_full;
    logic [REG_W-1:0] out_head;
    logic [WATCH_W-1:0] w_head;
    logic [3:0]       flags;

    assign sel       = msgq_sel_e'(host_sel);
    assign in_push   = host_wr_en && (sel == SEL_DATA) && ctrl_q[CT_IN_WEN];
    assign out_push  = eng_push && ctrl_q[CT_OUT_WEN];
    assign out_pop   = host_rd_en && (sel == SEL_DATA);
    assign watch_pop = host_rd_en && (sel == SEL_WATCH);
    assign mbox_clr  = host_wr_en && (sel == SEL_MBOX) && (host_wdata == MBOX_CLR_KEY);

    // Control register: host writable, undefined bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (host_wr_en && (sel == SEL_CTRL)) ctrl_q <= host_wdata & CTRL_MASK;
    end

    // Mailbox word: engine sets bits, host key write clears.
    always_ff @(posedge clk) begin
        if (!rst_n) mbox_q <= '0;
        else        mbox_q <= (mbox_clr ? '0 : mbox_q) | eng_mbox_set;
    end

    msgq_fifo #(.WIDTH(REG_W), .DEPTH(MSG_DEPTH)) in_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(in_push), .push_data(host_wdata),
        .pop(eng_pop), .head(eng_pop_data),
        .empty(in_empty), .full(in_full)
    );

    msgq_fifo #(.WIDTH(REG_W), .DEPTH(MSG_DEPTH)) out_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(out_push), .push_data(eng_push_data),
        .pop(out_pop), .head(out_head),
        .empty(out_empty), .full(out_full)
    );

    msgq_fifo #(.WIDTH(WATCH_W), .DEPTH(WATCH_DEPTH)) watch_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(eng_watch_push), .push_data(eng_watch_data),
        .pop(watch_pop), .head(w_head),
        .empty(w_empty), .full(w_full)
    );

    msgq_irq irq_i (
        .ctrl(ctrl_q), .out_ne(!out_empty), .in_empty(in_empty),
        .mbox_nz(mbox_q != '0), .watch_ne(!w_empty),
        .flags(flags), .irq(irq)
    );

    // Status word assembly.
    always_comb begin
        status                           = '0;
        status[ST_OUT_NE]                = !out_empty;
        status[ST_IN_NF]                 = !in_full;
        status[ST_OUT_NF]                = !out_full;
        status[ST_IN_NE]                 = !in_empty;
        status[ST_WF_INT:ST_MB_INT]      = flags;
    end

    // Host read multiplexer.
    always_comb begin
        case (sel)
            SEL_DATA:  host_rdata = out_head;
            SEL_STAT:  host_rdata = status;
            SEL_CTRL:  host_rdata = ctrl_q;
            SEL_MBOX:  host_rdata = mbox_q;
            SEL_WATCH: host_rdata = {!w_empty, w_head};
            default:   host_rdata = '0;
        endcase
    end

    assign eng_in_avail  = !in_empty;
    assign eng_out_space = !out_full;

    AST_IN_NF_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        in_empty && in_push && !eng_pop |=> !in_full && !in_empty); // R5
    AST_IN_WEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        in_empty && host_wr_en && (sel == SEL_DATA) && !ctrl_q[CT_IN_WEN]
        |=> in_empty); // R3
    AST_MBOX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_clr && (eng_mbox_set == '0) |=> mbox_q == '0); // R8
    AST_MBOX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_clr |=> (mbox_q & $past(mbox_q)) == $past(mbox_q)); // R8
    AST_OUT_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CT_OUT_IEN] && ctrl_q[CT_OUT_WEN] && out_empty && eng_push && !host_wr_en
        |=> irq); // R7
endmodule

// File: tb/msgq_mailbox_tb_top.sv
module msgq_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rdata;
    logic        eng_pop = 1'b0;
    logic [31:0] eng_pop_data;
    logic        eng_in_avail;
    logic        eng_push = 1'b0;
    logic [31:0] eng_push_data = '0;
    logic        eng_out_space;
    logic        eng_watch_push = 1'b0;
    logic [30:0] eng_watch_data = '0;
    logic [31:0] eng_mbox_set = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [2:0] I_DATA = 3'd0, I_STAT = 3'd1, I_CTRL = 3'd2,
                           I_MBOX = 3'd3, I_WATCH = 3'd4;
    localparam logic [31:0] RESET_STATUS = 32'h0006_0000;

    always #2 clk = ~clk;

    msgq_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rd_en(host_rd_en), .host_rdata(host_rdata),
        .eng_pop(eng_pop), .eng_pop_data(eng_pop_data), .eng_in_avail(eng_in_avail),
        .eng_push(eng_push), .eng_push_data(eng_push_data), .eng_out_space(eng_out_space),
        .eng_watch_push(eng_watch_push), .eng_watch_data(eng_watch_data),
        .eng_mbox_set(eng_mbox_set), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); host_sel = s; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic hread(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk); host_sel = s; host_rd_en = 1'b1;
        #1 d = host_rdata;
        @(negedge clk); host_rd_en = 1'b0;
    endtask

    task automatic hpeek(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk); host_sel = s;
        #1 d = host_rdata;
    endtask

    task automatic epush(input logic [31:0] d);
        @(negedge clk); eng_push_data = d; eng_push = 1'b1;
        @(negedge clk); eng_push = 1'b0;
    endtask

    task automatic epop(output logic [31:0] d);
        @(negedge clk); eng_pop = 1'b1;
        #1 d = eng_pop_data;
        @(negedge clk); eng_pop = 1'b0;
    endtask

    task automatic ewatch(input logic [30:0] d);
        @(negedge clk); eng_watch_data = d; eng_watch_push = 1'b1;
        @(negedge clk); eng_watch_push = 1'b0;
    endtask

    task automatic emset(input logic [31:0] b);
        @(negedge clk); eng_mbox_set = b;
        @(negedge clk); eng_mbox_set = '0;
    endtask

    function automatic logic [31:0] stat_word(input bit out_ne, input bit in_nf,
            input bit out_nf, input bit in_ne, input logic [3:0] fl);
        return (32'(out_ne) << 16) | (32'(in_nf) << 17) | (32'(out_nf) << 18) |
               (32'(in_ne) << 19) | (32'(fl) << 20);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hpeek(I_STAT, d); chk("R1 status", d, RESET_STATUS);
        hpeek(I_CTRL, d); chk("R1 control", d, 32'h0);
        hpeek(I_MBOX, d); chk("R1 mailbox", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R10 control mask
        hwrite(I_CTRL, 32'hFFFF_FFFF);
        hpeek(I_CTRL, d); chk("R10 control mask", d, 32'h0393_0000);
        hwrite(I_CTRL, 32'h0);

        // R3 write dropped when inbound disabled; R6 engine pop on empty
        hwrite(I_DATA, 32'h0000_0011);
        hpeek(I_STAT, d); chk("R3 dropped write", d, RESET_STATUS);
        epop(d); chk("R6 engine pop empty", d, 32'h0);

        // R3 R5 R6 inbound sweep
        hwrite(I_CTRL, 32'h0200_0000);
        for (int np = 0; np < 4; np++) begin
            for (int nq = 0; nq < 4; nq++) begin
                int acc;
                acc = (np > 2) ? 2 : np;
                for (int k = 0; k < np; k++) hwrite(I_DATA, 32'hA000_0000 | (np << 8) | k);
                hpeek(I_STAT, d);
                chk("R5 inbound fill status", d, stat_word(0, acc < 2, 1, acc > 0, 4'h0));
                chk("R2 eng_in_avail", {31'b0, eng_in_avail}, {31'b0, acc > 0});
                for (int k = 0; k < nq; k++) begin
                    epop(d);
                    chk("R3 inbound order", d, (k < acc) ? (32'hA000_0000 | (np << 8) | k) : 32'h0);
                end
                epop(d); epop(d);
                hpeek(I_STAT, d); chk("R6 inbound drained", d, RESET_STATUS);
            end
        end

        // R4 R5 R6 outbound sweep
        hwrite(I_CTRL, 32'h0100_0000);
        for (int np = 0; np < 4; np++) begin
            for (int nq = 0; nq < 4; nq++) begin
                int acc;
                acc = (np > 2) ? 2 : np;
                for (int k = 0; k < np; k++) epush(32'hB000_0000 | (np << 8) | k);
                hpeek(I_STAT, d);
                chk("R5 outbound fill status", d, stat_word(acc > 0, 1, acc < 2, 0, 4'h0));
                chk("R2 eng_out_space", {31'b0, eng_out_space}, {31'b0, acc < 2});
                for (int k = 0; k < nq; k++) begin
                    hread(I_DATA, d);
                    chk("R4 outbound order", d, (k < acc) ? (32'hB000_0000 | (np << 8) | k) : 32'h0);
                end
                hread(I_DATA, d); hread(I_DATA, d);
                hpeek(I_STAT, d); chk("R6 outbound drained", d, RESET_STATUS);
            end
        end

        // R7 interrupt sweep: enables against store conditions
        for (int en = 0; en < 16; en++) begin
            for (int cd = 0; cd < 16; cd++) begin
                logic [31:0] ien;
                logic [3:0]  fl;
                ien = (32'(en & 1) << 16) | (32'((en >> 1) & 1) << 17) |
                      (32'((en >> 2) & 1) << 20) | (32'((en >> 3) & 1) << 23);
                hwrite(I_CTRL, 32'h0300_0000);
                if (cd[0]) epush(32'h1);
                if (cd[1]) hwrite(I_DATA, 32'h2);
                if (cd[2]) emset(32'h1);
                if (cd[3]) ewatch(31'h3);
                hwrite(I_CTRL, 32'h0300_0000 | ien);
                fl[0] = en[2] && cd[2];
                fl[1] = en[1] && !cd[1];
                fl[2] = en[0] && cd[0];
                fl[3] = en[3] && cd[3];
                hpeek(I_STAT, d);
                chk("R7 status flags", d, stat_word(cd[0], 1, 1, cd[1], fl));
                chk("R7 irq", {31'b0, irq}, {31'b0, |fl});
                hread(I_DATA, d); epop(d);
                hwrite(I_MBOX, 32'h0000_F0F0);
                hread(I_WATCH, d);
            end
        end
        hwrite(I_CTRL, 32'h0);

        // R8 mailbox set and clear
        emset(32'h5); emset(32'h30);
        hpeek(I_MBOX, d); chk("R8 mailbox set", d, 32'h35);
        hwrite(I_MBOX, 32'h0000_1234);
        hpeek(I_MBOX, d); chk("R8 wrong key ignored", d, 32'h35);
        hwrite(I_MBOX, 32'h0000_F0F0);
        hpeek(I_MBOX, d); chk("R8 key clears", d, 32'h0);

        // R9 watch queue drain
        ewatch(31'h12); ewatch(31'h34); ewatch(31'h56);
        hread(I_WATCH, d); chk("R9 watch first", d, 32'h8000_0012);
        hread(I_WATCH, d); chk("R9 watch second", d, 32'h8000_0034);
        hread(I_WATCH, d); chk("R9 watch empty", d, 32'h0);

        // R6 host pop from empty outbound
        hread(I_DATA, d); chk("R6 host pop empty", d, 32'h0);
        hpeek(I_STAT, d); chk("R6 status unchanged", d, RESET_STATUS);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule